// File: doc/BRIEF.md
# Paged Data Memory Address Extender

This block sits on a DSP's 14-bit data memory bus, in front of external memory and I/O devices. It sorts every access into one of four address regions. Addresses below a programmable page-size boundary are the paged data window. A band above that boundary is I/O space. The top 2K words belong to the processor's on-chip memory. Any space left between the end of I/O and the on-chip region is unmapped.

Inside I/O space there is a page register at a fixed address. The processor loads it with an ordinary data memory write. Its low bits are placed above the in-page offset to form a wider external address, so the one data window can reach any of several external pages. Only the data window is banked. I/O and on-chip accesses never depend on the page.

Software reads the page register at the same address to learn which page is selected. A small set of I/O addresses directly above the page register produce one-hot port select strobes.

Top module: `dm_page_ext`

## Requirements
- R1: After reset the page register holds 0. The page bits of `ext_addr_o` are 0, and a read of the page register address returns 0.
- R2: `ext_addr_o` is always the low 4 bits of the page register followed by `dm_addr_i[12:0]`. `ext_cs_o` is 1 for an active access to an address below 0x2000 (the page size).
- R3: An access is active only when `dm_sel_i` is 1 and at least one of `rd_i` or `wr_i` is 1. Without an active access, `ext_cs_o`, `io_sel_o` and `pg_rdata_o` are all 0.
- R4: Addresses 0x3800 to 0x3FFF (on-chip) never assert `ext_cs_o` or any bit of `io_sel_o`.
- R5: An active write to 0x2000 loads `dm_wdata_i[7:0]` into the 8-bit page register at the clock edge. Its low 4 bits become the page bits of `ext_addr_o` from the next cycle.
- R6: During an active read of 0x2000, `pg_rdata_o` is the page register in bits 7:0, with bits 15:8 zero. At all other times `pg_rdata_o` is 0.
- R7: An active access to 0x2001+k (k = 0..3) sets only `io_sel_o[k]`. Every other address, including 0x2000, leaves `io_sel_o` at 0.
- R8: The page register keeps its value across every cycle that is not an active write to 0x2000. This includes writes to other I/O, data, on-chip or unmapped addresses, writes with `dm_sel_i` low, and reads of 0x2000.
- R9: Addresses 0x3000 to 0x37FF lie between the end of I/O space (0x2FFF) and the on-chip region. They assert neither `ext_cs_o` nor `io_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dm_addr_i | input | 14 | Data memory address |
| dm_wdata_i | input | 16 | Data bus value for writes |
| dm_sel_i | input | 1 | Data memory select, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ext_addr_o | output | 17 | Extended external address: page bits, then in-page offset |
| ext_cs_o | output | 1 | External data memory chip select |
| io_sel_o | output | 4 | One-hot I/O port selects |
| pg_rdata_o | output | 16 | Page register readback |

## Verification
Seeded random accesses are biased toward each region in turn: the data window, the I/O band near the page register, the unmapped gap, the on-chip region and the whole address space. Across these, select and strobe combinations vary.

These patterns separate four things: region decode errors at each boundary, select gating, a wrong one-hot bit, and a page register that loads on the wrong condition. Random page writes change the expected high address bits, so an error in page composition shows up in later data accesses.

Directed sequences load 0xA5 and then try every non-loading write kind. Read-back of the page register shows that its value is kept.

// File: rtl/dm_page_pkg.sv
package dm_page_pkg;
  typedef enum logic [1:0] {
    RGN_DATA   = 2'd0,
    RGN_IO     = 2'd1,
    RGN_ONCHIP = 2'd2,
    RGN_NONE   = 2'd3
  } region_e;
endpackage

// File: rtl/dm_region_decode.sv
module dm_region_decode
  import dm_page_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_SIZE   = 8192,
  parameter int IO_END      = 'h2FFF,
  parameter int ONCHIP_BASE = 'h3800,
  parameter int PG_ADDR     = 'h2000,
  parameter int N_IO        = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic              hit_pg_o,
  output logic [N_IO-1:0]   io_hit_o
);
  localparam logic [ADDR_W-1:0] PS_A  = ADDR_W'(PAGE_SIZE);
  localparam logic [ADDR_W-1:0] IOE_A = ADDR_W'(IO_END);
  localparam logic [ADDR_W-1:0] OCB_A = ADDR_W'(ONCHIP_BASE);
  localparam logic [ADDR_W-1:0] PG_A  = ADDR_W'(PG_ADDR);

  always_comb begin
    if (addr_i >= OCB_A)     region_o = RGN_ONCHIP;
    else if (addr_i < PS_A)  region_o = RGN_DATA;
    else if (addr_i <= IOE_A) region_o = RGN_IO;
    else                     region_o = RGN_NONE;
  end

  assign hit_pg_o = (region_o == RGN_IO) && (addr_i == PG_A);

  for (genvar k = 0; k < N_IO; k++) begin : g_io
    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PG_ADDR + 1 + k);
    assign io_hit_o[k] = (region_o == RGN_IO) && (addr_i == PORT_A);
  end
endmodule

// File: rtl/dm_page_reg.sv
module dm_page_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/dm_page_ext.sv
module dm_page_ext
  import dm_page_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 16,
  parameter int PAGE_SIZE   = 8192,
  parameter int IO_END      = 'h2FFF,
  parameter int ONCHIP_BASE = 'h3800,
  parameter int PG_ADDR     = 'h2000,
  parameter int REG_W       = 8,
  parameter int PAGE_BITS   = 4,
  parameter int N_IO        = 4,
  localparam int OFF_W      = $clog2(PAGE_SIZE),
  localparam int EXT_W      = PAGE_BITS + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dm_addr_i,
  input  logic [DATA_W-1:0] dm_wdata_i,
  input  logic              dm_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [EXT_W-1:0]  ext_addr_o,
  output logic              ext_cs_o,
  output logic [N_IO-1:0]   io_sel_o,
  output logic [DATA_W-1:0] pg_rdata_o
);
  region_e          region;
  logic             hit_pg;
  logic [N_IO-1:0]  io_hit;
  logic [REG_W-1:0] pg_q;
  logic             access;
  logic             pg_we;

  dm_region_decode #(
    .ADDR_W(ADDR_W), .PAGE_SIZE(PAGE_SIZE), .IO_END(IO_END),
    .ONCHIP_BASE(ONCHIP_BASE), .PG_ADDR(PG_ADDR), .N_IO(N_IO)
  ) u_dec (
    .addr_i(dm_addr_i), .region_o(region), .hit_pg_o(hit_pg), .io_hit_o(io_hit)
  );

  assign access = dm_sel_i && (rd_i || wr_i);
  assign pg_we  = dm_sel_i && wr_i && hit_pg;

  dm_page_reg #(.REG_W(REG_W)) u_pg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pg_we),
    .wdata_i(dm_wdata_i[REG_W-1:0]), .q_o(pg_q)
  );

  // offset never carries into page bits: plain concatenation
  assign ext_addr_o = {pg_q[PAGE_BITS-1:0], dm_addr_i[OFF_W-1:0]};
  assign ext_cs_o   = access && (region == RGN_DATA);
  assign io_sel_o   = access ? io_hit : '0;
  assign pg_rdata_o = (dm_sel_i && rd_i && hit_pg) ? DATA_W'(pg_q) : '0;
endmodule

// File: rtl/dm_page_ext_chk.sv
module dm_page_ext_chk #(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 16,
  parameter int PAGE_SIZE   = 8192,
  parameter int IO_END      = 'h2FFF,
  parameter int ONCHIP_BASE = 'h3800,
  parameter int PG_ADDR     = 'h2000,
  parameter int PAGE_BITS   = 4,
  parameter int N_IO        = 4,
  parameter int OFF_W       = 13,
  parameter int EXT_W       = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] dm_addr_i,
  input logic [DATA_W-1:0] dm_wdata_i,
  input logic              dm_sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [EXT_W-1:0]  ext_addr_o,
  input logic              ext_cs_o,
  input logic [N_IO-1:0]   io_sel_o,
  input logic [DATA_W-1:0] pg_rdata_o
);
  localparam logic [ADDR_W-1:0] OCB_A = ADDR_W'(ONCHIP_BASE);
  localparam logic [ADDR_W-1:0] PG_A  = ADDR_W'(PG_ADDR);

  initial begin
    p_param_map_r9: assert (PAGE_SIZE <= IO_END && IO_END <= 'h37FF &&
                            PG_ADDR >= PAGE_SIZE && PG_ADDR + N_IO <= IO_END)
      else $error("page map parameters out of range");
  end

  logic pg_wr;
  assign pg_wr = dm_sel_i && wr_i && (dm_addr_i == PG_A);

  p_cs_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_cs_o || io_sel_o != '0) |-> (dm_sel_i && (rd_i || wr_i)));

  p_onchip_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_addr_i >= OCB_A) |-> (!ext_cs_o && io_sel_o == '0));

  p_io_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_sel_o) && !(ext_cs_o && io_sel_o != '0));

  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cs_o |-> (ext_addr_o[OFF_W-1:0] == dm_addr_i[OFF_W-1:0]));

  p_page_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wr |=> (ext_addr_o[EXT_W-1:OFF_W] == $past(dm_wdata_i[PAGE_BITS-1:0])));

  p_page_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_wr |=> $stable(ext_addr_o[EXT_W-1:OFF_W]));

  p_rdata_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_rdata_o != '0) |-> (dm_sel_i && rd_i && dm_addr_i == PG_A));
endmodule

bind dm_page_ext dm_page_ext_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SIZE(PAGE_SIZE), .IO_END(IO_END),
  .ONCHIP_BASE(ONCHIP_BASE), .PG_ADDR(PG_ADDR), .PAGE_BITS(PAGE_BITS),
  .N_IO(N_IO), .OFF_W(OFF_W), .EXT_W(EXT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dm_addr_i(dm_addr_i), .dm_wdata_i(dm_wdata_i),
  .dm_sel_i(dm_sel_i), .rd_i(rd_i), .wr_i(wr_i), .ext_addr_o(ext_addr_o),
  .ext_cs_o(ext_cs_o), .io_sel_o(io_sel_o), .pg_rdata_o(pg_rdata_o)
);

// File: tb/dm_page_ext_tb_top.sv
module dm_page_ext_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] dm_addr_i = '0;
  logic [15:0] dm_wdata_i = '0;
  logic        dm_sel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [16:0] ext_addr_o;
  logic        ext_cs_o;
  logic [3:0]  io_sel_o;
  logic [15:0] pg_rdata_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mpg = 8'h00;

  always #5 clk_i = ~clk_i;

  dm_page_ext dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dm_addr_i(dm_addr_i), .dm_wdata_i(dm_wdata_i),
    .dm_sel_i(dm_sel_i), .rd_i(rd_i), .wr_i(wr_i), .ext_addr_o(ext_addr_o),
    .ext_cs_o(ext_cs_o), .io_sel_o(io_sel_o), .pg_rdata_o(pg_rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [13:0] a, input bit act);
    if (!act) return "R3";
    if (a >= 14'h3800) return "R4";
    if (a < 14'h2000) return "R2";
    if (a == 14'h2000) return "R6";
    if (a <= 14'h2FFF) return "R7";
    return "R9";
  endfunction

  function automatic logic [37:0] exp_out(input logic [13:0] a, input bit s, input bit r, input bit w);
    bit act = s && (r || w);
    logic [16:0] ea = {mpg[3:0], a[12:0]};
    logic cs = act && (a < 14'h2000);
    logic [3:0] io = '0;
    logic [15:0] rb = '0;
    if (act && a >= 14'h2001 && a <= 14'h2004) io = 4'b1 << (a - 14'h2001);
    if (s && r && a == 14'h2000) rb = {8'h00, mpg};
    return {ea, cs, io, rb};
  endfunction

  task automatic access(input logic [13:0] a, input logic [15:0] d, input bit s, input bit r, input bit w);
    logic [37:0] e;
    @(negedge clk_i);
    dm_addr_i = a; dm_wdata_i = d; dm_sel_i = s; rd_i = r; wr_i = w;
    #1;
    e = exp_out(a, s, r, w);
    chk({ext_addr_o, ext_cs_o, io_sel_o, pg_rdata_o} == e, tag_of(a, s && (r || w)),
        64'({ext_addr_o, ext_cs_o, io_sel_o, pg_rdata_o}), 64'(e));
    @(posedge clk_i);
    if (s && w && a == 14'h2000) mpg = d[7:0];
  endtask

  task automatic read_pg(input string tag);
    @(negedge clk_i);
    dm_addr_i = 14'h2000; dm_sel_i = 1'b1; rd_i = 1'b1; wr_i = 1'b0;
    #1;
    chk(pg_rdata_o == {8'h00, mpg}, tag, 64'(pg_rdata_o), 64'(mpg));
    @(posedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk(ext_addr_o[16:13] == 4'h0, "R1", 64'(ext_addr_o[16:13]), 64'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    read_pg("R1");

    // R5: load and use new page
    access(14'h2000, 16'hFFA5, 1'b1, 1'b0, 1'b1);
    read_pg("R5");
    @(negedge clk_i) dm_addr_i = 14'h1234; dm_sel_i = 1'b1; rd_i = 1'b1; wr_i = 1'b0;
    #1 chk(ext_addr_o == {4'h5, 13'h1234} && ext_cs_o, "R5", 64'(ext_addr_o), 64'({4'h5, 13'h1234}));

    // R8: non-loading writes keep page
    access(14'h2001, 16'h0033, 1'b1, 1'b0, 1'b1);
    access(14'h3900, 16'h0044, 1'b1, 1'b0, 1'b1);
    access(14'h0100, 16'h0055, 1'b1, 1'b0, 1'b1);
    access(14'h3100, 16'h0066, 1'b1, 1'b0, 1'b1);
    access(14'h2000, 16'h0077, 1'b0, 1'b0, 1'b1);
    access(14'h2000, 16'h0088, 1'b1, 1'b1, 1'b0);
    read_pg("R8");

    // corner addresses
    access(14'h1FFF, 16'h0, 1'b1, 1'b1, 1'b0);  // R2 top of window
    access(14'h2004, 16'h0, 1'b1, 1'b1, 1'b0);  // R7 last port
    access(14'h2005, 16'h0, 1'b1, 1'b0, 1'b1);  // R7 past ports
    access(14'h2FFF, 16'h0, 1'b1, 1'b1, 1'b0);  // R7 end of io
    access(14'h3000, 16'h0, 1'b1, 1'b1, 1'b0);  // R9 gap
    access(14'h37FF, 16'h0, 1'b1, 1'b1, 1'b0);  // R9 gap end
    access(14'h3800, 16'h0, 1'b1, 1'b1, 1'b0);  // R4
    access(14'h3FFF, 16'h0, 1'b1, 1'b0, 1'b1);  // R4
    access(14'h0000, 16'h0, 1'b0, 1'b1, 1'b0);  // R3 no select
    access(14'h0000, 16'h0, 1'b1, 1'b0, 1'b0);  // R3 no strobe

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [13:0] a;
      int op;
      case ($urandom % 8)
        0, 1, 2: a = 14'($urandom % 8192);
        3:       a = 14'h2000 + 14'($urandom % 8);
        4:       a = 14'h2000 + 14'($urandom % 4096);
        5:       a = 14'h3000 + 14'($urandom % 2048);
        6:       a = 14'h3800 + 14'($urandom % 2048);
        default: a = 14'($urandom);
      endcase
      op = $urandom % 4;
      access(a, 16'($urandom), ($urandom % 8) != 0, op == 1, op >= 2);
    end
    read_pg("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule